// File: doc/BRIEF.md
# Inset Capture Window and Horizontal Thinner

This block picks out the part of an incoming video raster that feeds a picture-in-picture inset and thins it horizontally by a programmable ratio. It runs on the acquisition pixel clock. It follows line and field start pulses to place a capture window whose top edge is a line count and whose left edge is a coarse sample offset. Inside that window it keeps a fraction N/96 of the valid samples, with N from 1 to 48. Kept samples leave on a write strobe with their data one cycle after they arrive.

Vertical thinning, filtering and storage of the kept samples belong to later stages. The ratio, start and range-mode fields are live inputs and are used on every cycle. A phase accumulator chooses which samples to keep. It restarts at each line start, so every line of a field is thinned with the same pattern.

Top module: `inset_acq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, wr_en_o is 0.
- R2: A kept sample shows up on wr_data_o with wr_en_o high exactly one clock after the cycle in which it was presented with smp_valid_i high. Cycles with smp_valid_i low never cause a write.
- R3: With ratio_i equal to 0, no sample is ever written.
- R4: With ratio_i = N in 1..48, let j be a valid sample's 0-based position inside the window on its line. That sample is written exactly when floor((j+1)·N/96) > floor(j·N/96). No two writes fall on consecutive cycles.
- R5: With ratio_i = 48, every second window sample is written, starting with the second one (j = 1, 3, 5, ...).
- R6: Values of ratio_i above 48 behave exactly like 48.
- R7: With wide_i = 1, the window on each line opens at the valid sample whose 0-based index since line start equals 8·hstart_i, over the full 4-bit range.
- R8: With wide_i = 0, only hstart_i[2:0] is used: the window opens at sample index 8·hstart_i[2:0], and bit 3 has no effect.
- R9: Lines are numbered from 0 at the first line_start_i pulse after a field_start_i pulse. Lines whose number is below vstart_i produce no writes. Lines at or above it are captured.
- R10: The thinning phase restarts at every line_start_i. Each line gives the same write pattern, whatever phase the previous line ended on.
- R11: Only valid samples advance the sample index and the phase. Invalid cycles between samples leave the write pattern, expressed in valid-sample positions, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Acquisition pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| field_start_i | input | 1 | One-cycle pulse at the start of a field |
| line_start_i | input | 1 | One-cycle pulse at the start of a line; a valid sample in the same cycle is that line's sample 0 |
| smp_valid_i | input | 1 | Sample-valid qualifier |
| smp_data_i | input | DATA_W | Incoming sample |
| hstart_i | input | 4 | Horizontal window start, in units of 8 samples |
| vstart_i | input | 8 | Vertical window start, in lines per field |
| wide_i | input | 1 | 1: full 16-step start range; 0: 8-step range |
| ratio_i | input | 6 | Thinning numerator N (ratio N/96) |
| wr_en_o | output | 1 | Write strobe for a kept sample |
| wr_data_o | output | DATA_W | Kept sample data |

## Verification
The thinning is driven with ratios 1, 7, 25, 32 and 47 over long contiguous lines. These ratios give sparse, irregular and dense keep patterns, so an off-by-one in the compare against 96 or in the carry-over of the remainder would show. Ratio 48 separates a strict "every other sample, second first" from a pattern that is shifted by one. Ratios 0, 49 and 63 separate the off case and the clamp from plain truncation. Start offsets 11 in both range modes and 3 in narrow mode show whether bit 3 is masked. A field with a vertical start of 3 checks the line numbering. Lines that end mid-phase, and lines with idle gaps between samples, show whether the phase restarts per line and advances only on valid samples.

// File: rtl/inset_acq_pkg.sv
package inset_acq_pkg;
  localparam int unsigned RED_DEN = 96;
  localparam int unsigned RED_MAX = 48;
  localparam int unsigned ACC_W   = 7;
  localparam int unsigned SUM_W   = ACC_W + 1;
endpackage

// File: rtl/inset_acq_vwin.sv
module inset_acq_vwin #(
  parameter int unsigned VSTART_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                field_start_i,
  input  logic                line_start_i,
  input  logic [VSTART_W-1:0] vstart_i,
  output logic                v_open_o
);
  localparam int unsigned LINE_W = VSTART_W + 1;
  localparam logic [LINE_W-1:0] LINE_SAT = '1;

  logic [LINE_W-1:0] lines_q, lines_cur;

  // lines_cur = number of line starts seen this field, including this cycle
  always_comb begin
    if (field_start_i)
      lines_cur = line_start_i ? LINE_W'(1) : '0;
    else if (line_start_i && lines_q != LINE_SAT)
      lines_cur = lines_q + LINE_W'(1);
    else
      lines_cur = lines_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lines_q <= '0;
    else         lines_q <= lines_cur;
  end

  // current line number is lines_cur-1; open when it reaches vstart
  assign v_open_o = lines_cur > {1'b0, vstart_i};
endmodule

// File: rtl/inset_acq_hwin.sv
module inset_acq_hwin #(
  parameter int unsigned HSTART_W = 4,
  parameter int unsigned HSTEP    = 8,
  parameter int unsigned PIX_W    = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_start_i,
  input  logic                smp_valid_i,
  input  logic [HSTART_W-1:0] hstart_i,
  input  logic                wide_i,
  output logic                h_open_o
);
  localparam logic [HSTART_W-1:0] NARROW_MASK = {1'b0, {(HSTART_W-1){1'b1}}};
  localparam logic [PIX_W-1:0]    PIX_SAT     = '1;

  logic [HSTART_W-1:0] start_sel;
  logic [PIX_W-1:0]    start_pix, idx_cur, pix_q;

  assign start_sel = wide_i ? hstart_i : (hstart_i & NARROW_MASK);
  assign start_pix = PIX_W'(start_sel) * PIX_W'(HSTEP);
  assign idx_cur   = line_start_i ? '0 : pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      pix_q <= '0;
    else if (smp_valid_i && idx_cur != PIX_SAT)
      pix_q <= idx_cur + PIX_W'(1);
    else
      pix_q <= idx_cur;
  end

  assign h_open_o = idx_cur >= start_pix;
endmodule

// File: rtl/inset_acq_thin.sv
module inset_acq_thin
  import inset_acq_pkg::*;
#(
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_start_i,
  input  logic               take_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               keep_o
);
  localparam logic [SUM_W-1:0]   DEN   = SUM_W'(RED_DEN);
  localparam logic [RATIO_W-1:0] R_MAX = RATIO_W'(RED_MAX);

  logic [RATIO_W-1:0] n_eff;
  logic [ACC_W-1:0]   acc_q, acc_base, acc_nxt;
  logic [SUM_W-1:0]   sum;

  assign n_eff    = (ratio_i > R_MAX) ? R_MAX : ratio_i;
  assign acc_base = line_start_i ? '0 : acc_q;
  assign sum      = SUM_W'(acc_base) + SUM_W'(n_eff);
  assign keep_o   = take_i && (sum >= DEN);

  always_comb begin
    if (!take_i)     acc_nxt = acc_base;
    else if (keep_o) acc_nxt = ACC_W'(sum - DEN);
    else             acc_nxt = ACC_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_nxt;
  end
endmodule

// File: rtl/inset_acq.sv
module inset_acq #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HSTART_W = 4,
  parameter int unsigned VSTART_W = 8,
  parameter int unsigned RATIO_W  = 6,
  parameter int unsigned HSTEP    = 8,
  parameter int unsigned PIX_W    = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                field_start_i,
  input  logic                line_start_i,
  input  logic                smp_valid_i,
  input  logic [DATA_W-1:0]   smp_data_i,
  input  logic [HSTART_W-1:0] hstart_i,
  input  logic [VSTART_W-1:0] vstart_i,
  input  logic                wide_i,
  input  logic [RATIO_W-1:0]  ratio_i,
  output logic                wr_en_o,
  output logic [DATA_W-1:0]   wr_data_o
);
  logic v_open, h_open, take, keep;

  inset_acq_vwin #(.VSTART_W(VSTART_W)) u_vwin (
    .clk_i, .rst_ni, .field_start_i, .line_start_i, .vstart_i,
    .v_open_o(v_open)
  );

  inset_acq_hwin #(.HSTART_W(HSTART_W), .HSTEP(HSTEP), .PIX_W(PIX_W)) u_hwin (
    .clk_i, .rst_ni, .line_start_i, .smp_valid_i, .hstart_i, .wide_i,
    .h_open_o(h_open)
  );

  assign take = smp_valid_i && v_open && h_open;

  inset_acq_thin #(.RATIO_W(RATIO_W)) u_thin (
    .clk_i, .rst_ni, .line_start_i, .take_i(take), .ratio_i,
    .keep_o(keep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= keep;
      if (keep) wr_data_o <= smp_data_i;
    end
  end
endmodule

// File: rtl/inset_acq_chk.sv
module inset_acq_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RATIO_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               smp_valid_i,
  input logic [DATA_W-1:0]  smp_data_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               wr_en_o,
  input logic [DATA_W-1:0]  wr_data_o
);
  assert_off_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == '0) |=> !wr_en_o);

  assert_invalid_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !wr_en_o);

  assert_data_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> (!wr_en_o || wr_data_o == $past(smp_data_i)));

  assert_no_adjacent_writes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
endmodule

bind inset_acq inset_acq_chk #(.DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_chk (
  .clk_i, .rst_ni, .smp_valid_i, .smp_data_i, .ratio_i, .wr_en_o, .wr_data_o
);

// File: tb/inset_acq_test.sv
`timescale 1ns/1ps
module inset_acq_test;
  localparam time CYC = 20ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       field_start_i = 1'b0, line_start_i = 1'b0, smp_valid_i = 1'b0;
  logic [7:0] smp_data_i = '0;
  logic [3:0] hstart_i = '0;
  logic [7:0] vstart_i = '0;
  logic       wide_i = 1'b1;
  logic [5:0] ratio_i = '0;
  logic       wr_en_o;
  logic [7:0] wr_data_o;

  int checks = 0, fails = 0, m_lines = 0;
  bit done = 0;
  logic       pend_en = 1'b0;
  logic [7:0] pend_d = '0;
  string      pend_req = "R1";

  always #(CYC/2) clk_i = ~clk_i;

  inset_acq uut (.*);

  function automatic bit kept(int j, int n);
    return n != 0 && (((j + 1) * n) / 96 > (j * n) / 96);
  endfunction

  task automatic check_pend();
    checks++;
    if (wr_en_o !== pend_en || (pend_en && wr_data_o !== pend_d)) begin
      fails++;
      $display("FAIL %s: wr_en=%b data=%h expected wr_en=%b data=%h",
               pend_req, wr_en_o, wr_data_o, pend_en, pend_d);
    end
  endtask

  task automatic step(logic fs, logic ls, logic v, logic [7:0] d,
                      logic e_en, string req);
    @(negedge clk_i);
    check_pend();
    field_start_i = fs; line_start_i = ls; smp_valid_i = v; smp_data_i = d;
    pend_en = e_en; pend_d = d; pend_req = req;
  endtask

  task automatic new_field(string req);
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, req);
    m_lines = 0;
  endtask

  // one line: line-start cycle, nsamp valid samples with gap idle cycles after each
  task automatic run_line(int nsamp, int gap, string req);
    int nc, start, lnum;
    nc = (ratio_i > 6'd48) ? 48 : int'(ratio_i);
    start = 8 * int'(wide_i ? hstart_i : (hstart_i & 4'h7));
    m_lines++;
    lnum = m_lines - 1;
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, req);
    for (int i = 0; i < nsamp; i++) begin
      logic [7:0] d;
      bit e;
      d = 8'(i * 3 + lnum * 17);
      e = (lnum >= int'(vstart_i)) && (i >= start) && kept(i - start, nc);
      step(1'b0, 1'b0, 1'b1, d, e, req);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, 8'hxx ^ 8'h00, 1'b0, req);
    end
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, req);
  endtask

  task automatic t_reset();
    ratio_i = 6'd48;
    for (int k = 0; k < 4; k++) step(1'b0, k == 0, 1'b1, 8'(k), 1'b0, "R1");
    @(negedge clk_i); check_pend(); rst_ni = 1'b1;
    smp_valid_i = 1'b0; line_start_i = 1'b0; pend_en = 1'b0; pend_req = "R1";
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R1");
  endtask

  task automatic t_ratios();
    int rs[5] = '{1, 7, 25, 32, 47};
    wide_i = 1'b1; hstart_i = 4'd0; vstart_i = 8'd0;
    foreach (rs[k]) begin
      ratio_i = 6'(rs[k]);
      new_field("R4");
      run_line(110, 0, "R4");
    end
    ratio_i = 6'd25;
    new_field("R2");
    run_line(40, 0, "R2");
  endtask

  task automatic t_half();
    ratio_i = 6'd48; new_field("R5"); run_line(40, 0, "R5");
  endtask

  task automatic t_off();
    ratio_i = 6'd0; new_field("R3"); run_line(60, 0, "R3");
  endtask

  task automatic t_clamp();
    ratio_i = 6'd49; new_field("R6"); run_line(40, 0, "R6");
    ratio_i = 6'd63; run_line(40, 0, "R6");
  endtask

  task automatic t_hwide();
    wide_i = 1'b1; hstart_i = 4'd11; ratio_i = 6'd48;
    new_field("R7"); run_line(120, 0, "R7");
    hstart_i = 4'd15; ratio_i = 6'd32; run_line(140, 0, "R7");
  endtask

  task automatic t_hnarrow();
    wide_i = 1'b0; ratio_i = 6'd48;
    hstart_i = 4'd11; new_field("R8"); run_line(60, 0, "R8");
    hstart_i = 4'd3; run_line(60, 0, "R8");
    wide_i = 1'b1; hstart_i = 4'd0;
  endtask

  task automatic t_vstart();
    vstart_i = 8'd3; ratio_i = 6'd32;
    new_field("R9");
    for (int l = 0; l < 6; l++) run_line(30, 0, "R9");
    vstart_i = 8'd0;
  endtask

  task automatic t_phase();
    ratio_i = 6'd7; new_field("R10");
    for (int l = 0; l < 3; l++) run_line(50, 0, "R10");
  endtask

  task automatic t_gaps();
    ratio_i = 6'd25; new_field("R11");
    run_line(60, 2, "R11");
    run_line(40, 1, "R11");
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_half();
    t_off();
    t_clamp();
    t_hwide();
    t_hnarrow();
    t_vstart();
    t_phase();
    t_gaps();
    @(negedge clk_i); check_pend();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CYC * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule